// File: doc/BRIEF.md
# Two-Phase Scan Shift Register

This block models the readout scanner of a linear image sensor as synchronous logic. The sensor's two complementary element clocks, `phi1` and `phi2`, and its active-low start input reach the block as plain pins. A faster system clock samples all three through synchronizers and edge detectors, so every state change happens on the `clk` edge.

A start request is accepted only when exactly one `phi1` rising edge falls inside the low period of `start_n`. The next `phi1` rise then selects element 1. Each later `phi1` rise moves to the next element, and element `N` is the last. The selected element is shown both as a zero-based index and as a one-hot vector. A one-cycle video strobe marks the `phi2` rise inside each element slot.

The end-of-scan flag rises on the `phi1` fall during the slot of element `N-1`. It stays high through the slot of element `N`. The `phi1` rise that closes the last slot returns the scanner to idle.

Start windows with the wrong number of `phi1` rises set a sticky protocol-error flag. Start requests made while the scanner is busy set a sticky overrun flag. Neither kind of request starts a scan, and only reset clears the two flags. No output carries a data payload and nothing can push back on the block, so the outputs follow the element clocks directly with no valid/ready handshake. The element count `N` is a parameter, normally 64 or 128.

Top module: `two_phase_scanner`

## Requirements
- R1: After reset, `elem_idx` is 0. `elem_sel`, `vid_stb`, `eos`, `busy`, `proto_err` and `overrun` are all 0.
- R2: A start request is accepted only if `phi1` rises exactly once while `start_n` is low. The first `phi1` rise after `start_n` returns high selects element 1 (`elem_idx` = 0).
- R3: A start window with zero `phi1` rises, or with two or more, starts no scan and sets `proto_err` to 1. `proto_err` stays 1 until reset.
- R4: During a scan, each `phi1` rise advances `elem_idx` by exactly one. The index runs from 0 to N-1 in ascending order.
- R5: While an element is selected, `elem_sel` has exactly one bit set, bit `elem_idx`. Otherwise `elem_sel` is all zero.
- R6: `vid_stb` pulses for one `clk` cycle on each `phi2` rise during a scan. This gives exactly N strobes per scan, one per element, in index order.
- R7: `eos` rises on the `phi1` fall while `elem_idx` = N-2. It is high at the strobes of elements N-2 and N-1 and low at all earlier strobes.
- R8: The `phi1` rise that ends the last element's slot clears `busy`, `eos` and `elem_sel`, and returns `elem_idx` to 0.
- R9: A start request (`start_n` falling) while `busy` is 1 is ignored. The running scan completes unchanged, and `overrun` is set to 1 until reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, several times faster than the element clocks |
| rst_n | input | 1 | Active-low asynchronous reset |
| phi1 | input | 1 | Element clock phase 1 (asynchronous) |
| phi2 | input | 1 | Element clock phase 2, complement of phi1 (asynchronous) |
| start_n | input | 1 | Active-low start request (asynchronous) |
| elem_idx | output | $clog2(N) | Zero-based index of the selected element |
| elem_sel | output | N | One-hot element select, zero when idle |
| vid_stb | output | 1 | One-cycle strobe at each phi2 rise during a scan |
| eos | output | 1 | End-of-scan flag |
| busy | output | 1 | Scanner armed or scanning |
| proto_err | output | 1 | Sticky start-window protocol error |
| overrun | output | 1 | Sticky flag: start request arrived while busy |

## Verification
The assertions assume that `phi1` and `phi2` hold each level for more `clk` cycles than the synchronizer depth. They also assume that `start_n` never changes in the same `clk` cycle as a `phi1` edge, so that every edge is seen once and in order. The stimulus derives both phases from one counter in the `clk` domain, with a random half period of four to ten cycles. It moves `start_n` two `clk` cycles after a `phi1` fall or rise, which keeps every start edge well away from a phase edge.

// File: rtl/scan_pkg.sv
package scan_pkg;
  typedef enum logic [1:0] {
    SC_IDLE  = 2'd0,
    SC_ARMED = 2'd1,
    SC_SCAN  = 2'd2
  } scan_state_e;
endpackage

// File: rtl/edge_sync.sv
module edge_sync #(
  parameter int W = 3,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] rise,
  output logic [W-1:0] fall
);
  logic [W-1:0] pipe [STAGES];
  logic [W-1:0] prev;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe[s] <= RST_VAL;
        else if (s == 0) pipe[s] <= d;
        else pipe[s] <= pipe[(s > 0) ? s - 1 : 0];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev <= RST_VAL;
    else prev <= pipe[STAGES-1];
  end

  assign rise = pipe[STAGES-1] & ~prev;
  assign fall = ~pipe[STAGES-1] & prev;
endmodule

// File: rtl/start_qual.sv
module start_qual (
  input  logic clk,
  input  logic rst_n,
  input  logic st_fall,
  input  logic st_rise,
  input  logic p1_rise,
  input  logic busy,
  output logic go,
  output logic proto_err,
  output logic overrun
);
  logic       win;
  logic [1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win       <= 1'b0;
      cnt       <= 2'd0;
      go        <= 1'b0;
      proto_err <= 1'b0;
      overrun   <= 1'b0;
    end else begin
      go <= 1'b0;
      if (st_fall) begin
        if (busy) overrun <= 1'b1;
        else begin
          win <= 1'b1;
          cnt <= p1_rise ? 2'd1 : 2'd0;
        end
      end else if (win && p1_rise && cnt != 2'd2) begin
        cnt <= cnt + 2'd1;
      end
      if (st_rise && win) begin
        win <= 1'b0;
        if (cnt == 2'd1 && !p1_rise) go <= 1'b1;
        else proto_err <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/scan_core.sv
module scan_core
  import scan_pkg::*;
#(
  parameter int N = 64,
  localparam int AW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go,
  input  logic          p1_rise,
  input  logic          p1_fall,
  input  logic          p2_rise,
  output logic [AW-1:0] addr,
  output logic [N-1:0]  sel,
  output logic          vid,
  output logic          eos,
  output logic          busy
);
  localparam logic [AW-1:0] LAST = AW'(N - 1);
  localparam logic [AW-1:0] PENULT = AW'(N - 2);

  scan_state_e state;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= SC_IDLE;
      addr  <= '0;
      vid   <= 1'b0;
      eos   <= 1'b0;
    end else begin
      vid <= p2_rise && (state == SC_SCAN);
      unique case (state)
        SC_IDLE:  if (go) state <= SC_ARMED;
        SC_ARMED: if (p1_rise) begin
          state <= SC_SCAN;
          addr  <= '0;
        end
        SC_SCAN: begin
          if (p1_rise) begin
            if (addr == LAST) begin
              state <= SC_IDLE;
              addr  <= '0;
              eos   <= 1'b0;
            end else begin
              addr <= addr + 1'b1;
            end
          end else if (p1_fall && addr == PENULT) begin
            eos <= 1'b1;
          end
        end
        default: state <= SC_IDLE;
      endcase
    end
  end

  assign busy = (state != SC_IDLE);

  generate
    for (genvar i = 0; i < N; i++) begin : g_sel
      assign sel[i] = (state == SC_SCAN) && (addr == AW'(i));
    end
  endgenerate
endmodule

// File: rtl/two_phase_scanner.sv
module two_phase_scanner #(
  parameter int N = 64,
  parameter int SYNC_STAGES = 2,
  localparam int AW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          phi1,
  input  logic          phi2,
  input  logic          start_n,
  output logic [AW-1:0] elem_idx,
  output logic [N-1:0]  elem_sel,
  output logic          vid_stb,
  output logic          eos,
  output logic          busy,
  output logic          proto_err,
  output logic          overrun
);
  logic [2:0] rise, fall;
  logic       go;

  edge_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({start_n, phi2, phi1}),
    .rise(rise), .fall(fall)
  );

  start_qual u_qual (
    .clk(clk), .rst_n(rst_n), .st_fall(fall[2]), .st_rise(rise[2]),
    .p1_rise(rise[0]), .busy(busy), .go(go),
    .proto_err(proto_err), .overrun(overrun)
  );

  scan_core #(.N(N)) u_core (
    .clk(clk), .rst_n(rst_n), .go(go), .p1_rise(rise[0]),
    .p1_fall(fall[0]), .p2_rise(rise[1]),
    .addr(elem_idx), .sel(elem_sel), .vid(vid_stb), .eos(eos), .busy(busy)
  );
endmodule

// File: rtl/scan_chk.sv
module scan_chk #(
  parameter int N = 64,
  localparam int AW = $clog2(N)
) (
  input logic          clk,
  input logic          rst_n,
  input logic [AW-1:0] elem_idx,
  input logic [N-1:0]  elem_sel,
  input logic          vid_stb,
  input logic          eos,
  input logic          busy,
  input logic          proto_err,
  input logic          overrun
);
  AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(elem_sel)); // R5
  AST_SEL_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (elem_sel == '0 && elem_idx == '0 && !eos)); // R8
  AST_STB_SELECTED: assert property (@(posedge clk) disable iff (!rst_n)
    vid_stb |-> ($countones(elem_sel) == 1 && elem_sel[elem_idx])); // R6
  AST_IDX_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (elem_sel != '0 && $past(elem_sel) != '0 && elem_idx != $past(elem_idx))
      |-> elem_idx == $past(elem_idx) + 1'b1); // R4
  AST_EOS_LATE: assert property (@(posedge clk) disable iff (!rst_n)
    eos |-> elem_idx >= AW'(N - 2)); // R7
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    proto_err |=> proto_err); // R3
  AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |=> overrun); // R9
endmodule

bind two_phase_scanner scan_chk #(.N(N)) u_chk (
  .clk(clk), .rst_n(rst_n), .elem_idx(elem_idx), .elem_sel(elem_sel),
  .vid_stb(vid_stb), .eos(eos), .busy(busy), .proto_err(proto_err),
  .overrun(overrun)
);

// File: tb/two_phase_scanner_tb.sv
module two_phase_scanner_tb;
  localparam int CLK_PERIOD = 10;
  localparam int N = 8;
  localparam int AW = $clog2(N);

  logic clk = 1'b0, rst_n = 1'b0, phi1 = 1'b1, phi2 = 1'b0, start_n = 1'b1;
  logic [AW-1:0] elem_idx;
  logic [N-1:0]  elem_sel;
  logic vid_stb, eos, busy, proto_err, overrun;

  int errors = 0, checks = 0;
  int half = 4, ph = 0;
  int strobes = 0;
  bit mon_en = 1'b0;
  logic eos_q = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    ph <= (ph + 1 >= 2 * half) ? 0 : ph + 1;
    phi1 <= (ph + 1 >= 2 * half) || (ph + 1 < half);
    phi2 <= !((ph + 1 >= 2 * half) || (ph + 1 < half));
  end

  two_phase_scanner #(.N(N)) u_dut (
    .clk(clk), .rst_n(rst_n), .phi1(phi1), .phi2(phi2), .start_n(start_n),
    .elem_idx(elem_idx), .elem_sel(elem_sel), .vid_stb(vid_stb), .eos(eos),
    .busy(busy), .proto_err(proto_err), .overrun(overrun)
  );

  function automatic logic [N-1:0] exp_sel(int idx);
    return N'(1) << idx;
  endfunction

  function automatic logic exp_eos(int idx);
    return idx >= N - 2;
  endfunction

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (mon_en && vid_stb) begin
      chk(elem_idx == AW'(strobes), "R4", "index at strobe", elem_idx, strobes);
      chk(elem_sel == exp_sel(strobes), "R5", "one-hot select", elem_sel, exp_sel(strobes));
      chk(eos == exp_eos(strobes), "R7", "eos at strobe", eos, exp_eos(strobes));
      strobes++;
    end
    if (mon_en && eos && !eos_q)
      chk(elem_idx == AW'(N - 2), "R7", "eos rise index", elem_idx, N - 2);
    eos_q <= eos;
  end

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0; start_n = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic start_good();
    @(negedge phi1); repeat (2) @(negedge clk); start_n = 1'b0;
    @(negedge phi1); repeat (2) @(negedge clk); start_n = 1'b1;
  endtask

  task automatic finish_scan(bit with_overrun);
    int guard = 0;
    strobes = 0;
    mon_en = 1'b1;
    start_good();
    while (strobes < N && guard < 4 * N * 2 * half + 200) begin
      @(negedge clk); guard++;
      if (with_overrun && strobes == 2 && start_n) begin
        start_n = 1'b0; repeat (3) @(negedge clk); start_n = 1'b1;
      end
    end
    chk(strobes == N, "R6", "strobe count", strobes, N);
    @(posedge phi1); repeat (6) @(negedge clk);
    mon_en = 1'b0;
    chk(!busy && !eos && elem_sel == '0 && elem_idx == '0, "R8", "idle after scan",
        {busy, eos, |elem_sel}, 0);
  endtask

  initial begin
    do_reset();
    chk(elem_idx == '0 && elem_sel == '0 && !vid_stb && !eos && !busy &&
        !proto_err && !overrun, "R1", "reset state",
        {elem_sel, vid_stb, eos, busy, proto_err, overrun}, 0);

    finish_scan(1'b0);
    chk(!proto_err && !overrun, "R2", "clean start flags", {proto_err, overrun}, 0);

    void'($urandom(32'd1234));
    for (int k = 0; k < 5; k++) begin
      half = 4 + int'($urandom % 7);
      repeat (2 + int'($urandom % 20)) @(negedge clk);
      finish_scan(1'b0);
      chk(!proto_err, "R2", "random-period start", proto_err, 0);
    end

    half = 5;
    finish_scan(1'b1);
    chk(overrun == 1'b1, "R9", "overrun flag set", overrun, 1);
    repeat (4 * half) @(negedge clk);
    chk(overrun == 1'b1, "R9", "overrun sticky", overrun, 1);

    do_reset();
    @(posedge phi1); repeat (2) @(negedge clk); start_n = 1'b0;
    repeat (2) @(negedge clk); start_n = 1'b1;
    repeat (8 * half) @(negedge clk);
    chk(proto_err == 1'b1, "R3", "zero phi1 rises", proto_err, 1);
    chk(!busy && !vid_stb, "R3", "no scan after zero rises", busy, 0);

    do_reset();
    @(negedge phi1); repeat (2) @(negedge clk); start_n = 1'b0;
    @(negedge phi1); @(negedge phi1); repeat (2) @(negedge clk); start_n = 1'b1;
    repeat (8 * half) @(negedge clk);
    chk(proto_err == 1'b1, "R3", "two phi1 rises", proto_err, 1);
    chk(!busy, "R3", "no scan after two rises", busy, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule